// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous burst SRAM. Address and command enter on a rising edge. The data transfer for that command takes place in the bus cycle that ends at the second enabled edge after it. Reads and writes use the same slot, so any mix of them can be issued on consecutive cycles with no idle gap. Read data comes from an output register. For each write, the data and byte selects are sampled at that second edge. The bidirectional data bus is modelled as a separate input, output and output-enable.

A read issued directly after a write to the same word has to see the pending write. The block merges the write bytes arriving on the bus into the array word it returns. Writes two or more slots older are already stored. A load cycle starts a new access. An advance cycle continues the last access at the next address of a four-beat burst, in either linear or interleaved order. A low clock enable freezes the whole block.

Top module: `pipe_sram`

## Requirements
- R1: After reset `dq_oe` is 0, and no access is in flight.
- R2: A read loaded at enabled edge k drives the addressed word on `dq_out`, with `dq_oe` = 1, from enabled edge k+1 until the next enabled edge.
- R3: A write loaded at enabled edge k samples `dq_in` and `byte_sel` at enabled edge k+2. Lane i occupies bits [9i+8:9i] and is updated only when `byte_sel[i]` = 1; the other lanes keep their contents.
- R4: Reads and writes issued on consecutive enabled edges in any order each complete correctly, with no idle cycle between them.
- R5: A read loaded on the edge right after a write to the same address returns the write's selected lanes merged with the stored values of the other lanes.
- R6: `dq_oe` is 0 during the data phase of a write, which is the cycle after enabled edge k+1.
- R7: A load cycle selects the block only when `en_a_n` = 0, `en_b` = 1 and `en_c_n` = 0. Any other pattern is a deselect: `dq_oe` is 0 in its data phase and no location is written.
- R8: While `clk_en` = 0, no command is accepted, no location is written, and `dq_out` and `dq_oe` hold their values.
- R9: With `adv_ld` = 1 the previous access continues on the same upper address bits, and `wr_en` is ignored. The two low address bits step through four beats and then wrap to the first beat.
- R10: `burst_ilv` is sampled on a load cycle. With `burst_ilv` = 0, beat n uses low bits (start+n) mod 4. With `burst_ilv` = 1, beat n uses low bits start XOR n.
- R11: An advance cycle that follows a deselect is also a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load new access, 1 = advance burst |
| wr_en | input | 1 | 1 = write, 0 = read, on load cycles |
| byte_sel | input | LANES | Per-lane write select, sampled with write data |
| burst_ilv | input | 1 | Burst order on load: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| dq_in | input | LANE_W*LANES | Write data from the bus |
| dq_out | output | LANE_W*LANES | Registered read data |
| dq_oe | output | 1 | Output drive enable for the data bus |

## Verification
The block is driven with read/write alternation on consecutive edges to separate addresses, which shows that slots do not collide. It is also driven with a read right after a write to the same word using partial lane selects; this separates correct forwarding from stale array data, from whole-word forwarding, and from lane misplacement. Bursts are started at a non-zero low address in both orders and run past four beats, which tells the linear and interleaved sequences apart and exposes wrap errors. Clock-enable stalls inside bursts and write data phases, and deselects that use each chip-enable pin with garbage data present, show that frozen or unselected cycles leave the outputs and storage alone.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } sram_op_e;

   // low address bits of beat cnt of a burst that started at start
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      logic [1:0] r;
      if (ilv) r = start ^ cnt;
      else     r = start + cnt;
      return r;
   endfunction

endpackage

// File: rtl/psram_burst_ctr.sv
module psram_burst_ctr
   import pipe_sram_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          adv_ld,
   input  logic          sel_ok,
   input  logic          wr_en,
   input  logic          burst_ilv,
   input  logic [AW-1:0] addr,
   output sram_op_e      cmd_op,
   output logic [AW-1:0] cmd_addr
);

   sram_op_e      act_op, nxt_op;
   logic [AW-1:0] base_q, nxt_base;
   logic [1:0]    cnt_q, nxt_cnt;
   logic          ilv_q, nxt_ilv;

   always_comb begin
      nxt_op   = act_op;
      nxt_base = base_q;
      nxt_cnt  = cnt_q;
      nxt_ilv  = ilv_q;
      if (!adv_ld) begin
         nxt_base = addr;
         nxt_cnt  = 2'd0;
         nxt_ilv  = burst_ilv;
         if (!sel_ok)    nxt_op = OP_NONE;
         else if (wr_en) nxt_op = OP_WR;
         else            nxt_op = OP_RD;
      end else if (act_op != OP_NONE) begin
         nxt_cnt = cnt_q + 2'd1;
      end
   end

   assign cmd_op   = nxt_op;
   assign cmd_addr = {nxt_base[AW-1:2], beat_low(nxt_base[1:0], nxt_cnt, nxt_ilv)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_op <= OP_NONE;
         base_q <= '0;
         cnt_q  <= 2'd0;
         ilv_q  <= 1'b0;
      end else if (clk_en) begin
         act_op <= nxt_op;
         base_q <= nxt_base;
         cnt_q  <= nxt_cnt;
         ilv_q  <= nxt_ilv;
      end
   end

   // R9: an advance steps the beat count by one, wrapping after four
   a_r9_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_ld && act_op != OP_NONE) |=> (cnt_q == $past(cnt_q) + 2'd1))
      else $error("beat counter did not step");

   // R11: advancing a deselected access stays deselected
   a_r11_adv_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv_ld && act_op == OP_NONE) |=> (act_op == OP_NONE))
      else $error("advance after deselect started an access");

endmodule

// File: rtl/psram_lane_merge.sv
module psram_lane_merge #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic [LANE_W*LANES-1:0] old_word,
   input  logic [LANE_W*LANES-1:0] new_word,
   input  logic [LANES-1:0]        lane_en,
   output logic [LANE_W*LANES-1:0] merged
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_word[g*LANE_W +: LANE_W]
                                                     : old_word[g*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/psram_store.sv
module psram_store #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter int AW     = 6
) (
   input  logic                    clk,
   input  logic                    wr_go,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANE_W*LANES-1:0] wr_data,
   input  logic [LANES-1:0]        wr_lanes,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANE_W*LANES-1:0] rd_data
);

   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_go && wr_lanes[g])
            cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
      assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
   end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
   import pipe_sram_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter int AW     = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en,
   input  logic                    en_a_n,
   input  logic                    en_b,
   input  logic                    en_c_n,
   input  logic                    adv_ld,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        byte_sel,
   input  logic                    burst_ilv,
   input  logic [AW-1:0]           addr,
   input  logic [LANE_W*LANES-1:0] dq_in,
   output logic [LANE_W*LANES-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DW = LANE_W * LANES;

   if (AW < 2) begin : g_chk_aw
      $error("pipe_sram: AW must cover the two burst bits");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_chk_lane
      $error("pipe_sram: lane width and lane count must be positive");
   end

   logic          sel_ok;
   sram_op_e      cmd_op, s1_op, s2_op;
   logic [AW-1:0] cmd_addr, s1_addr, s2_addr;
   logic [DW-1:0] arr_word, rd_word;
   logic          fwd_hit;
   logic [LANES-1:0] fwd_lanes;

   assign sel_ok = !en_a_n && en_b && !en_c_n;

   psram_burst_ctr #(.AW(AW)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .adv_ld    (adv_ld),
      .sel_ok    (sel_ok),
      .wr_en     (wr_en),
      .burst_ilv (burst_ilv),
      .addr      (addr),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr)
   );

   // two-slot command pipeline: s1 = address slot, s2 = write data slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_op   <= OP_NONE;
         s2_op   <= OP_NONE;
         s1_addr <= '0;
         s2_addr <= '0;
      end else if (clk_en) begin
         s1_op   <= cmd_op;
         s1_addr <= cmd_addr;
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
      end
   end

   psram_store #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) i_store (
      .clk      (clk),
      .wr_go    (clk_en && s2_op == OP_WR),
      .wr_addr  (s2_addr),
      .wr_data  (dq_in),
      .wr_lanes (byte_sel),
      .rd_addr  (s1_addr),
      .rd_data  (arr_word)
   );

   // the write committing on this edge is not yet in the array
   assign fwd_hit   = (s2_op == OP_WR) && (s2_addr == s1_addr);
   assign fwd_lanes = fwd_hit ? byte_sel : '0;

   psram_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) i_merge (
      .old_word (arr_word),
      .new_word (dq_in),
      .lane_en  (fwd_lanes),
      .merged   (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_out <= '0;
         dq_oe  <= 1'b0;
      end else if (clk_en) begin
         dq_oe <= (s1_op == OP_RD);
         if (s1_op == OP_RD) dq_out <= rd_word;
      end
   end

   // R2: a loaded read drives the bus in its data phase
   a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv_ld && sel_ok && !wr_en) ##1 clk_en |=> dq_oe)
      else $error("read data phase not driven");

   // R6: no drive during a write data phase
   a_r6_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv_ld && sel_ok && wr_en) ##1 clk_en |=> !dq_oe)
      else $error("bus driven during write data phase");

   // R7: deselect leaves the bus undriven
   a_r7_desel_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv_ld && !sel_ok) ##1 clk_en |=> !dq_oe)
      else $error("bus driven after deselect");

   // R8: a stalled edge changes no output
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(dq_out) && $stable(dq_oe)))
      else $error("outputs moved while clock enable low");

endmodule

// File: tb/test_pipe_sram.sv
`timescale 1ns/1ps
module test_pipe_sram;

   localparam int LW = 9;
   localparam int NL = 4;
   localparam int AWB = 6;
   localparam int DW = LW * NL;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en, en_a_n, en_b, en_c_n, adv_ld, wr_en, burst_ilv;
   logic [NL-1:0] byte_sel;
   logic [AWB-1:0] addr;
   logic [DW-1:0] dq_in, dq_out;
   logic          dq_oe;

   always #4 clk = ~clk;

   pipe_sram #(.LANE_W(LW), .LANES(NL), .AW(AWB)) i_pipe_sram (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .en_a_n(en_a_n), .en_b(en_b),
      .en_c_n(en_c_n), .adv_ld(adv_ld), .wr_en(wr_en), .byte_sel(byte_sel),
      .burst_ilv(burst_ilv), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference storage and burst model
   logic [DW-1:0]  ref_mem [1 << AWB];
   int             m_op = 0;
   logic [AWB-1:0] m_base = '0;
   logic [1:0]     m_cnt = 2'd0;
   bit             m_ilv = 0;

   // ops of the last two enabled edges
   int             p1_kind = 0, p2_kind = 0, ph_kind = 0;
   logic [DW-1:0]  p1_wd = '0, p2_wd = '0;
   logic [NL-1:0]  p1_wbs = '0, p2_wbs = '0;
   logic [AWB-1:0] p1_addr = '0;
   string          p1_tag = "R1", ph_tag = "R1";
   bit             last_eff = 1;

   logic [DW-1:0]  rdq [$];
   bit             exp_oe = 0;
   logic [DW-1:0]  exp_dq = '0;

   function automatic logic [DW-1:0] rnd_word();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[DW-1:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // monitor: compares outputs after the previous edge
   task automatic check_outputs();
      string ctag;
      if (last_eff) begin
         exp_oe = (ph_kind == 1);
         if (exp_oe) exp_dq = rdq.pop_front();
         ctag = (ph_kind == 2) ? "R6" : ph_tag;
      end else begin
         ctag = "R8";
      end
      chk(dq_oe === exp_oe, ctag, "dq_oe", DW'(dq_oe), DW'(exp_oe));
      if (exp_oe) chk(dq_out === exp_dq, ctag, "dq_out", dq_out, exp_dq);
   endtask

   // driver: one clock of stimulus; pushes expected read words
   task automatic step(input bit ce, input bit adv, input bit we, input bit sel,
                       input logic [AWB-1:0] a, input bit ilv,
                       input logic [DW-1:0] wd, input logic [NL-1:0] wbs);
      int k;
      logic [1:0] lo;
      logic [AWB-1:0] ea;
      string t;
      @(negedge clk);
      check_outputs();
      clk_en = ce; adv_ld = adv; wr_en = we; addr = a; burst_ilv = ilv;
      en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
      if (!sel) begin
         k = $urandom % 3;
         if (k == 0) en_a_n = 1'b1;
         else if (k == 1) en_b = 1'b0;
         else en_c_n = 1'b1;
      end
      last_eff = ce;
      if (!ce) begin
         dq_in = rnd_word();
         byte_sel = NL'($urandom);
         return;
      end
      dq_in    = (p2_kind == 2) ? p2_wd : rnd_word();
      byte_sel = (p2_kind == 2) ? p2_wbs : NL'($urandom);
      ph_kind = p1_kind;
      ph_tag  = p1_tag;
      if (!adv) begin
         m_base = a; m_cnt = 2'd0; m_ilv = ilv;
         m_op = sel ? (we ? 2 : 1) : 0;
      end else if (m_op != 0) begin
         m_cnt = m_cnt + 2'd1;
      end
      lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ea = {m_base[AWB-1:2], lo};
      if (m_op == 0)      t = adv ? "R11" : "R7";
      else if (m_op == 2) t = "R3";
      else if (adv)       t = m_ilv ? "R10" : "R9";
      else if (p1_kind == 2 && p1_addr == ea) t = "R5";
      else if (p1_kind == 2) t = "R4";
      else                t = "R2";
      if (m_op == 1) rdq.push_back(ref_mem[ea]);
      else if (m_op == 2) begin
         for (int i = 0; i < NL; i++)
            if (wbs[i]) ref_mem[ea][i*LW +: LW] = wd[i*LW +: LW];
      end
      p2_kind = p1_kind; p2_wd = p1_wd; p2_wbs = p1_wbs;
      p1_kind = m_op; p1_wd = wd; p1_wbs = wbs; p1_addr = ea; p1_tag = t;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, '0, 0, '0, '0);
   endtask

   initial begin
      rst_n = 1'b0; clk_en = 1'b1; adv_ld = 1'b0; wr_en = 1'b0;
      en_a_n = 1'b1; en_b = 1'b0; en_c_n = 1'b1; burst_ilv = 1'b0;
      addr = '0; dq_in = '0; byte_sel = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(dq_oe === 1'b0, "R1", "dq_oe after reset", DW'(dq_oe), '0);

      // fill every word with full-lane writes, back to back
      for (int a = 0; a < (1 << AWB); a++)
         step(1, 0, 1, 1, AWB'(a), 0, rnd_word(), '1);
      idle(2);

      // R3: partial lane write, read later
      step(1, 0, 1, 1, 6'd5, 0, rnd_word(), 4'b0101);
      idle(2);
      step(1, 0, 0, 1, 6'd5, 0, '0, '0);
      idle(2);

      // R5: read right after a write to the same word
      step(1, 0, 1, 1, 6'd9, 0, rnd_word(), 4'b1010);
      step(1, 0, 0, 1, 6'd9, 0, '0, '0);
      step(1, 0, 1, 1, 6'd9, 0, rnd_word(), 4'b0001);
      step(1, 0, 0, 1, 6'd9, 0, '0, '0);
      idle(2);

      // R4: alternating read/write on distinct words
      step(1, 0, 0, 1, 6'd1, 0, '0, '0);
      step(1, 0, 1, 1, 6'd2, 0, rnd_word(), '1);
      step(1, 0, 0, 1, 6'd3, 0, '0, '0);
      step(1, 0, 1, 1, 6'd4, 0, rnd_word(), 4'b0110);
      step(1, 0, 0, 1, 6'd2, 0, '0, '0);
      step(1, 0, 0, 1, 6'd4, 0, '0, '0);
      idle(2);

      // R9 linear burst from low bits 2, past the wrap; R10 interleaved
      step(1, 0, 0, 1, 6'd22, 0, '0, '0);
      for (int i = 0; i < 5; i++) step(1, 1, 1, 1, '0, 1, '0, '0);
      step(1, 0, 0, 1, 6'd22, 1, '0, '0);
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, '0, 0, '0, '0);
      // burst write, then read it back
      step(1, 0, 1, 1, 6'd45, 1, rnd_word(), '1);
      for (int i = 0; i < 3; i++) step(1, 1, 0, 1, '0, 0, rnd_word(), NL'($urandom));
      step(1, 0, 0, 1, 6'd44, 0, '0, '0);
      for (int i = 0; i < 3; i++) step(1, 1, 0, 1, '0, 0, '0, '0);
      idle(2);

      // R8: stalls inside a read burst and a write data phase
      step(1, 0, 0, 1, 6'd30, 0, '0, '0);
      step(0, 0, 1, 1, 6'd7, 0, '0, '0);
      step(1, 1, 0, 1, '0, 0, '0, '0);
      step(0, 1, 0, 1, '0, 0, '0, '0);
      step(0, 1, 0, 1, '0, 0, '0, '0);
      step(1, 0, 1, 1, 6'd30, 0, rnd_word(), 4'b1100);
      step(0, 0, 0, 1, '0, 0, '0, '0);
      step(1, 0, 0, 1, 6'd30, 0, '0, '0);
      step(0, 0, 0, 1, '0, 0, '0, '0);
      idle(3);

      // R7 deselected writes with data on the bus, R11 advance after deselect
      step(1, 0, 1, 0, 6'd11, 0, rnd_word(), '1);
      step(1, 1, 1, 0, '0, 0, rnd_word(), '1);
      step(1, 1, 0, 1, '0, 0, '0, '0);
      step(1, 0, 0, 1, 6'd11, 0, '0, '0);
      step(1, 0, 0, 1, 6'd8, 0, '0, '0);
      idle(2);

      // random mixed traffic
      for (int i = 0; i < 3000; i++)
         step(($urandom % 8) != 0, ($urandom % 3) == 0, $urandom % 2,
              ($urandom % 6) != 0, AWB'($urandom), $urandom % 2,
              rnd_word(), NL'($urandom));
      idle(4);
      @(negedge clk);
      check_outputs();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule